// File: doc/BRIEF.md
# Streaming Load Line Buffer

This block sits between a core's load/store port and a memory line-fill port. It keeps one private copy of a 64-byte line that was brought in by a streaming load to write-combining memory. The line never enters a cache. Further streaming loads that want parts of the line not yet handed out get their data from this copy, with no new memory traffic. The line is held as four 16-byte chunks, and each chunk has its own consumed bit.

A load can be narrow (128 bits, one chunk) or wide (256 bits, two adjacent chunks). An address that is not aligned to the load's size raises a fault, and the load returns no data. Ordinary loads, streaming loads to memory that is not write-combining, and loads that miss are all served by a line fill. Only a streaming load to write-combining memory installs the fetched line in the buffer. The buffered line is dropped when any of these happens:
- an ordinary load reads it,
- a streaming load to memory of another type reads it,
- a store touches it,
- a streaming load asks again for a chunk already consumed,
- the flush input is raised.

The load port is a valid/ready request. Responses, fill requests and faults come out of registers. While a fill is outstanding, `reqReady` stays low and the port stalls.

Top module: `stream_line_buf`

## Requirements
- R1: A load with `reqStream`=0, or with `reqWc`=0, is always served by a line fill and never installs the fetched line. A later streaming load to that line still fetches.
- R2: A streaming load to write-combining memory that misses raises `fillReqValid`. `fillReqAddr` is the 64-byte-aligned line address (bits [5:0] are zero). The returned line is installed. Chunk c of a line occupies `fillRspData[128c+127:128c]`, and the chunk index of an address is addr[5:4].
- R3: A streaming write-combining load whose chunks are all in the buffered line and all unconsumed raises `rspValid` in the cycle after acceptance, with no fill. The consumed bits of those chunks are then set.
- R4: A narrow load returns its chunk in `rspData[127:0]`, with `rspData[255:128]` zero. A wide load returns chunk addr[5:4] in the low half and the next chunk in the high half, and consumes both chunks.
- R5: A narrow load with addr[3:0]≠0, or a wide load with addr[4:0]≠0, raises `fault` in the cycle after acceptance. It gives no `rspValid` and no fill, and leaves the buffer unchanged.
- R6: An ordinary load to the buffered line invalidates the buffer.
- R7: A streaming load to non-write-combining memory that hits the buffered line invalidates the buffer.
- R8: A streaming load that asks for an already-consumed chunk invalidates the buffer and is served by a fill. The fill is installed with only that load's chunks marked consumed.
- R9: A store (`reqWrite`=1) to the buffered line invalidates the buffer. A store to another line has no effect. A store produces neither `rspValid` nor `fault`.
- R10: `flush` invalidates the buffer. When `flush` is high in the same cycle as a load that would hit, the flush wins and the load is served by a fill.
- R11: While a fill is outstanding, `reqReady` is low. `fillReqValid` and `fillReqAddr` hold steady until `fillReqReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop the buffered line |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle if valid |
| reqAddr | input | ADDR_W | Byte address |
| reqWrite | input | 1 | Request is a store |
| reqStream | input | 1 | Load carries the streaming hint |
| reqWc | input | 1 | Target region is write-combining |
| reqWide | input | 1 | 256-bit load (else 128-bit) |
| fillReqValid | output | 1 | Line fill request |
| fillReqReady | input | 1 | Memory takes the fill request |
| fillReqAddr | output | ADDR_W | Aligned line address of the fill |
| fillRspValid | input | 1 | Fill data present |
| fillRspData | input | LINE_BYTES*8 | Whole line in one beat |
| rspValid | output | 1 | Load data valid |
| rspData | output | 2*CHUNK_BYTES*8 | Load data |
| fault | output | 1 | General-protection fault for a misaligned load |

## Verification
The flush input and a streaming hit can land in the same cycle, and invalidation must take priority over serving the hit. The bench sets up a buffered line that has an unconsumed chunk. It then raises `flush` in the very cycle that a streaming load to that chunk is presented. The pass condition is that a fill request appears and the data comes from the fill rather than from the buffer. A follow-up load then shows that the refetched line was installed again with only that chunk consumed.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } slbState_e;

  // Strobes from the control to the datapath, one per action in a cycle
  typedef struct packed {
    logic latchReq;     // remember the pending load (line, chunk, size)
    logic serveHit;     // answer from the buffered line, mark chunks used
    logic captureFill;  // answer from the fill beat
    logic install;      // write the fill beat into the buffer
    logic invalidate;   // drop the buffered line
  } slbStrobe_t;
endpackage

// File: rtl/slb_ctrl.sv
module slb_ctrl
  import slb_pkg::*;
#(
  parameter int CHUNK_BYTES = 16,
  localparam int CSH = $clog2(CHUNK_BYTES)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         reqStream,
  input  logic         reqWc,
  input  logic         reqWide,
  input  logic [CSH:0] alignOff,
  input  logic         lineHit,
  input  logic         chunksFresh,
  input  logic         fillReqReady,
  input  logic         fillRspValid,
  output slbStrobe_t   strobe,
  output logic         reqReady,
  output logic         fillReqValid,
  output logic         rspValid,
  output logic         fault
);
  slbState_e state, stateNext;
  logic installPend, installPendNext;
  logic rspNext, faultNext;
  logic misAligned, useBuf;

  assign reqReady     = (state == ST_IDLE);
  assign fillReqValid = (state == ST_FETCH);
  assign useBuf       = reqStream && reqWc;
  assign misAligned   = reqWide ? (alignOff != '0) : (alignOff[CSH-1:0] != '0);

  always_comb begin
    strobe            = '0;
    strobe.invalidate = flush;
    stateNext         = state;
    installPendNext   = installPend;
    rspNext           = 1'b0;
    faultNext         = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            if (lineHit) strobe.invalidate = 1'b1;
          end else if (misAligned) begin
            faultNext = 1'b1;
          end else if (useBuf && lineHit && chunksFresh && !flush) begin
            strobe.serveHit = 1'b1;
            rspNext         = 1'b1;
          end else begin
            if (lineHit) strobe.invalidate = 1'b1;
            strobe.latchReq = 1'b1;
            installPendNext = useBuf;
            stateNext       = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (fillReqReady) stateNext = ST_WAIT;
        if (flush) installPendNext = 1'b0;
      end
      ST_WAIT: begin
        if (flush) installPendNext = 1'b0;
        if (fillRspValid) begin
          strobe.captureFill = 1'b1;
          strobe.install     = installPend && !flush;
          rspNext            = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      installPend <= 1'b0;
      rspValid    <= 1'b0;
      fault       <= 1'b0;
    end else begin
      state       <= stateNext;
      installPend <= installPendNext;
      rspValid    <= rspNext;
      fault       <= faultNext;
    end
  end
endmodule

// File: rtl/slb_data.sv
module slb_data
  import slb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  localparam int CHUNKS  = LINE_BYTES / CHUNK_BYTES,
  localparam int CHUNK_W = CHUNK_BYTES * 8,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int RSP_W   = 2 * CHUNK_W,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int CSH     = $clog2(CHUNK_BYTES),
  localparam int CIDX_W  = $clog2(CHUNKS),
  localparam int TAG_W   = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  slbStrobe_t            strobe,
  input  logic [ADDR_W-1:CSH]   reqAddrHi,
  input  logic                  reqWide,
  input  logic [LINE_W-1:0]     fillRspData,
  output logic                  lineHit,
  output logic                  chunksFresh,
  output logic [ADDR_W-1:0]     fillReqAddr,
  output logic [RSP_W-1:0]      rspData
);
  logic              lineValid;
  logic [TAG_W-1:0]  lineTag, pendTag, reqTag;
  logic [CIDX_W-1:0] pendIdx, reqIdx;
  logic              pendWide;
  logic [CHUNKS-1:0] readMask, reqMask, pendMask;
  logic [LINE_W-1:0] lineData;
  logic [RSP_W-1:0]  rspQ;

  function automatic logic [CHUNKS-1:0] chunkMask(input logic [CIDX_W-1:0] idx,
                                                  input logic wide);
    logic [CHUNKS-1:0] m;
    m = '0;
    for (int c = 0; c < CHUNKS; c++)
      if (c == int'(idx) || (wide && c == int'(idx) + 1)) m[c] = 1'b1;
    return m;
  endfunction

  function automatic logic [RSP_W-1:0] pickChunks(input logic [LINE_W-1:0] line,
                                                  input logic [CIDX_W-1:0] idx,
                                                  input logic wide);
    logic [CHUNK_W-1:0] lo, hi;
    lo = '0;
    hi = '0;
    for (int c = 0; c < CHUNKS; c++) begin
      if (c == int'(idx)) lo = line[c*CHUNK_W +: CHUNK_W];
      if (wide && c == int'(idx) + 1) hi = line[c*CHUNK_W +: CHUNK_W];
    end
    return {hi, lo};
  endfunction

  assign reqTag      = reqAddrHi[ADDR_W-1:OFF_W];
  assign reqIdx      = reqAddrHi[OFF_W-1:CSH];
  assign reqMask     = chunkMask(reqIdx, reqWide);
  assign pendMask    = chunkMask(pendIdx, pendWide);
  assign lineHit     = lineValid && (lineTag == reqTag);
  assign chunksFresh = (readMask & reqMask) == '0;
  assign fillReqAddr = {pendTag, {OFF_W{1'b0}}};
  assign rspData     = rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= 1'b0;
    end else begin
      if (strobe.install)    lineValid <= 1'b1;
      if (strobe.invalidate) lineValid <= 1'b0;
    end
  end

  // one consumed bit per chunk
  for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              readMask[g] <= 1'b0;
      else if (strobe.install)                readMask[g] <= pendMask[g];
      else if (strobe.serveHit && reqMask[g]) readMask[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineTag  <= '0;
      pendTag  <= '0;
      pendIdx  <= '0;
      pendWide <= 1'b0;
      rspQ     <= '0;
    end else begin
      if (strobe.latchReq) begin
        pendTag  <= reqTag;
        pendIdx  <= reqIdx;
        pendWide <= reqWide;
      end
      if (strobe.install)     lineTag <= pendTag;
      if (strobe.serveHit)    rspQ <= pickChunks(lineData, reqIdx, reqWide);
      if (strobe.captureFill) rspQ <= pickChunks(fillRspData, pendIdx, pendWide);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.install) lineData <= fillRspData;
  end
endmodule

// File: rtl/stream_line_buf.sv
module stream_line_buf
  import slb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CHUNK_BYTES = 16,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int RSP_W  = 2 * CHUNK_BYTES * 8,
  localparam int CSH    = $clog2(CHUNK_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqStream,
  input  logic              reqWc,
  input  logic              reqWide,
  output logic              fillReqValid,
  input  logic              fillReqReady,
  output logic [ADDR_W-1:0] fillReqAddr,
  input  logic              fillRspValid,
  input  logic [LINE_W-1:0] fillRspData,
  output logic              rspValid,
  output logic [RSP_W-1:0]  rspData,
  output logic              fault
);
  slbStrobe_t strobe;
  logic lineHit, chunksFresh;

  slb_ctrl #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqStream(reqStream), .reqWc(reqWc), .reqWide(reqWide),
    .alignOff(reqAddr[CSH:0]), .lineHit(lineHit), .chunksFresh(chunksFresh),
    .fillReqReady(fillReqReady), .fillRspValid(fillRspValid), .strobe(strobe),
    .reqReady(reqReady), .fillReqValid(fillReqValid), .rspValid(rspValid),
    .fault(fault)
  );

  slb_data #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddrHi(reqAddr[ADDR_W-1:CSH]),
    .reqWide(reqWide), .fillRspData(fillRspData), .lineHit(lineHit),
    .chunksFresh(chunksFresh), .fillReqAddr(fillReqAddr), .rspData(rspData)
  );
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 16,
  localparam int CSH = $clog2(CHUNK_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqStream,
  input logic              reqWc,
  input logic              reqWide,
  input logic              fillReqValid,
  input logic              fillReqReady,
  input logic [ADDR_W-1:0] fillReqAddr,
  input logic              rspValid,
  input logic              fault
);
  logic takeLoad, badAlign;
  assign takeLoad = reqValid && reqReady && !reqWrite;
  assign badAlign = reqWide ? (reqAddr[CSH:0] != '0) : (reqAddr[CSH-1:0] != '0);

  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !(fault && rspValid)); // R5
  AST_MISALIGN_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (takeLoad && badAlign) |=> (fault && !fillReqValid)); // R5
  AST_PLAIN_LOAD_FETCHES: assert property (@(posedge clk) disable iff (!rstN)
    (takeLoad && !badAlign && !(reqStream && reqWc)) |=> fillReqValid); // R1
  AST_FILL_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> (fillReqAddr[5:0] == 6'd0)); // R2
  AST_STALL_DURING_FILL: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> !reqReady); // R11
  AST_FILL_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (fillReqValid && !fillReqReady) |=> (fillReqValid && $stable(fillReqAddr))); // R11
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (!rspValid && !fault)); // R9
endmodule

bind stream_line_buf slb_checker #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES)) u_chk (.*);

// File: tb/stream_line_buf_test.sv
`timescale 1ns/1ps
module stream_line_buf_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0, reqValid = 1'b0, reqWrite = 1'b0, reqStream = 1'b0;
  logic reqWc = 1'b0, reqWide = 1'b0, fillReqReady = 1'b1, fillRspValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [511:0] fillRspData = '0;
  logic reqReady, fillReqValid, rspValid, fault;
  logic [31:0] fillReqAddr;
  logic [255:0] rspData;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  stream_line_buf uut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic stream, wc, wide, wr, fl, expRsp, expFault;
    logic [1:0] expFills;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  // addr, stream, wc, wide, write, flush, rsp, fault, fills, requirement
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 1,1,0,0,0, 1,0, 2'd1, 4'd2},  // R2 miss installs
    '{32'h1010, 1,1,0,0,0, 1,0, 2'd0, 4'd3},  // R3 hit
    '{32'h1020, 1,1,1,0,0, 1,0, 2'd0, 4'd4},  // R4 wide hit chunks 2,3
    '{32'h1010, 1,1,0,0,0, 1,0, 2'd1, 4'd8},  // R8 repeat refetch
    '{32'h1000, 1,1,0,0,0, 1,0, 2'd0, 4'd8},  // R8 only chunk1 marked
    '{32'h1008, 1,1,0,0,0, 0,1, 2'd0, 4'd5},  // R5 narrow misaligned
    '{32'h1030, 1,1,1,0,0, 0,1, 2'd0, 4'd5},  // R5 wide misaligned
    '{32'h1020, 1,1,0,0,0, 1,0, 2'd0, 4'd5},  // R5 buffer untouched
    '{32'h1030, 1,0,0,0,0, 1,0, 2'd1, 4'd7},  // R7 non-WC hit
    '{32'h1030, 1,1,0,0,0, 1,0, 2'd1, 4'd7},  // R7 invalidated
    '{32'h1000, 0,1,0,0,0, 1,0, 2'd1, 4'd6},  // R6 ordinary load
    '{32'h1000, 1,1,0,0,0, 1,0, 2'd1, 4'd6},  // R6 invalidated
    '{32'h1010, 0,0,0,1,0, 0,0, 2'd0, 4'd9},  // R9 store to line
    '{32'h1010, 1,1,0,0,0, 1,0, 2'd1, 4'd9},  // R9 invalidated
    '{32'h2000, 0,0,0,1,0, 0,0, 2'd0, 4'd9},  // R9 store elsewhere
    '{32'h1020, 1,1,0,0,0, 1,0, 2'd0, 4'd9},  // R9 still buffered
    '{32'h2000, 0,1,0,0,0, 1,0, 2'd1, 4'd1},  // R1 ordinary other line
    '{32'h1030, 1,1,0,0,0, 1,0, 2'd0, 4'd1},  // R1 buffer kept
    '{32'h2010, 1,0,0,0,0, 1,0, 2'd1, 4'd1},  // R1 non-WC stream
    '{32'h2010, 1,1,0,0,0, 1,0, 2'd1, 4'd1},  // R1 was not installed
    '{32'h3000, 1,1,1,0,0, 1,0, 2'd1, 4'd2},  // R2 wide miss replaces
    '{32'h2010, 1,1,0,0,0, 1,0, 2'd1, 4'd2},  // R2 old line gone
    '{32'h2020, 1,1,0,0,1, 1,0, 2'd1, 4'd10}, // R10 flush beats hit
    '{32'h2030, 1,1,0,0,0, 1,0, 2'd0, 4'd10}, // R10 refetch installed
    '{32'h2020, 1,1,1,0,0, 1,0, 2'd1, 4'd8},  // R8 wide repeat
    '{32'h3004, 0,1,0,0,0, 0,1, 2'd0, 4'd5},  // R5 ordinary misaligned
    '{32'h3030, 1,1,0,0,0, 1,0, 2'd1, 4'd2}   // R2 another miss
  };

  function automatic logic [31:0] wordAt(input logic [31:0] a);
    return (a * 32'h01000193) ^ 32'h5A5A5A5A;
  endfunction

  function automatic logic [511:0] mkLine(input logic [31:0] la);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[32*w +: 32] = wordAt(la + 32'(4*w));
    return l;
  endfunction

  function automatic logic [127:0] chunkAt(input logic [31:0] a);
    logic [127:0] c;
    for (int j = 0; j < 4; j++) c[32*j +: 32] = wordAt({a[31:4], 4'h0} + 32'(4*j));
    return c;
  endfunction

  task automatic check(input bit ok, input int req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [31:0] a, input logic st, input logic wc,
                      input logic wd, input logic wr, input logic fl, input int hold,
                      output logic gotRsp, output logic gotFault,
                      output logic [255:0] d, output int fills);
    logic [31:0] la;
    gotRsp = 1'b0; gotFault = 1'b0; d = '0; fills = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqStream = st; reqWc = wc; reqWide = wd;
    reqWrite = wr; flush = fl; fillReqReady = (hold == 0);
    @(negedge clk);
    reqValid = 1'b0; flush = 1'b0;
    if (wr) begin
      gotRsp = rspValid; gotFault = fault;
    end else begin
      for (int k = 0; k < 30 && !(gotRsp || gotFault); k++) begin
        if (rspValid) begin
          gotRsp = 1'b1; d = rspData;
        end else if (fault) begin
          gotFault = 1'b1;
        end else if (fillReqValid) begin
          fills++;
          check(!reqReady, 11, "ready low during fill", 256'(reqReady), 256'(0));
          check(fillReqAddr == {a[31:6], 6'd0}, 2, "fill line address",
                256'(fillReqAddr), 256'({a[31:6], 6'd0}));
          la = fillReqAddr;
          for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(fillReqValid && !reqReady && fillReqAddr == la, 11,
                  "fill request held", 256'({fillReqValid, reqReady}), 256'(2'b10));
          end
          fillReqReady = 1'b1;
          @(negedge clk);
          fillRspValid = 1'b1; fillRspData = mkLine(la);
          @(negedge clk);
          fillRspValid = 1'b0;
        end else begin
          @(negedge clk);
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic r, f;
    logic [255:0] d, expD;
    int n;
    repeat (3) @(negedge clk);
    // reset state (R11, R3)
    check(reqReady && !fillReqValid, 11, "reset ready, no fill",
          256'({reqReady, fillReqValid}), 256'(2'b10));
    check(!rspValid && !fault, 3, "reset no response",
          256'({rspValid, fault}), 256'(0));
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].addr, VECS[i].stream, VECS[i].wc, VECS[i].wide, VECS[i].wr,
           VECS[i].fl, 0, r, f, d, n);
      check(r == VECS[i].expRsp, VECS[i].req, $sformatf("row %0d rspValid", i),
            256'(r), 256'(VECS[i].expRsp));
      check(f == VECS[i].expFault, VECS[i].req, $sformatf("row %0d fault", i),
            256'(f), 256'(VECS[i].expFault));
      check(n == int'(VECS[i].expFills), VECS[i].req, $sformatf("row %0d fills", i),
            256'(n), 256'(VECS[i].expFills));
      if (VECS[i].expRsp) begin
        expD = VECS[i].wide ? {chunkAt(VECS[i].addr + 32'd16), chunkAt(VECS[i].addr)}
                            : {128'd0, chunkAt(VECS[i].addr)};
        check(d == expD, 4, $sformatf("row %0d data", i), d, expD);  // R4
      end
    end

    // R10: flush alone in idle drops the line
    doOp(32'h4000, 1, 1, 0, 0, 0, 0, r, f, d, n);
    check(n == 1, 2, "flush setup miss", 256'(n), 256'(1));
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    doOp(32'h4010, 1, 1, 0, 0, 0, 0, r, f, d, n);
    check(n == 1 && r, 10, "miss after flush", 256'(n), 256'(1));

    // R11: fill request stalled by memory for three cycles
    doOp(32'h5020, 1, 1, 1, 0, 0, 3, r, f, d, n);
    expD = {chunkAt(32'h5030), chunkAt(32'h5020)};
    check(r && n == 1 && d == expD, 11, "stalled fill data", d, expD);
    check(reqReady, 11, "ready back after fill", 256'(reqReady), 256'(1));
    doOp(32'h5000, 1, 1, 1, 0, 0, 0, r, f, d, n);
    check(r && n == 0, 3, "hit after stalled fill", 256'(n), 256'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule